// File: doc/BRIEF.md
# Hardware Thread Issue Selector

This block decides, on every clock cycle, which of several hardware thread contexts may hand its next instruction to a shared pipeline. The chosen thread is given as a one-hot grant vector and as a binary index. The index selects that thread's register file bank, so a change of thread costs no extra cycle. The grant is computed combinationally from the current flags and a small amount of stored state. Consecutive cycles can therefore name different threads with no empty slot between them.

Three scheduling modes are available. In the rotating mode the grant moves on every cycle. In the sticky mode a thread keeps the grant until it stops being eligible. In the weighted mode only threads 0 and 1 compete, and two small weights fix how the issue slots are shared between them. A thread that reports a load stall leaves the eligible set until the memory side reports that the load has completed. A thread whose ready flag is low is also passed over.

Top module: `mt_issue_sel`

## Requirements
- R1: Whenever `issue_vld` is high, `issue_gnt` has exactly one bit set, that bit is the one at position `issue_idx`, and the granted thread has its `thr_ready` bit high.
- R2: When no thread is eligible (eligible means ready and not waiting on a load), `issue_vld` is low and `issue_gnt` is all zeros.
- R3: With `sched_mode` = 2'b00 (rotating), the grant goes to the first eligible thread found by searching upward with wrap-around from a start pointer. After each grant the start pointer becomes the granted index plus one. With all threads eligible the grant therefore steps 0,1,2,3,0 on consecutive cycles.
- R4: With `sched_mode` = 2'b01 (sticky), the search uses the same order but starts at the last granted thread. That thread keeps the grant while it stays eligible. When it leaves the eligible set, the next eligible thread in rotating order is granted in the same cycle.
- R5: A high `ld_stall[i]` in a cycle makes thread i ineligible from the next cycle on. The thread stays ineligible until the cycle after the one in which `ld_done[i]` is high. If both flags are high in the same cycle, the stall wins.
- R6: With `sched_mode[1]` = 1 (weighted), and while threads 0 and 1 are both eligible, each window of `wt_a` + `wt_b` slots gives `wt_a` slots to thread 0 first and then `wt_b` slots to thread 1. For example, weights 3 and 1 give 0,0,0,1 repeating, and weights 1 and 2 give 0,1,1 repeating. If both weights are zero, thread 0 is always chosen.
- R7: In weighted mode threads 2 and up are never granted. If only one of threads 0 and 1 is eligible, that thread is granted and the window position is left unchanged.
- R8: A synchronous active-high `rst` clears the start pointer to thread 0, clears the window counters and clears every load-wait flag. The first rotating grant after reset, with all threads ready, is therefore thread 0.
- R9: Whenever at least one thread is eligible, `issue_vld` is high in that same cycle. A change of granted thread never inserts a cycle without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sched_mode | input | 2 | 00 rotating, 01 sticky, 1x weighted two-thread |
| wt_a | input | WW | Slot weight of thread 0 in weighted mode |
| wt_b | input | WW | Slot weight of thread 1 in weighted mode |
| thr_ready | input | NT | Per-thread ready flag |
| ld_stall | input | NT | Per-thread pulse: the thread now waits on a load |
| ld_done | input | NT | Per-thread pulse: the outstanding load has completed |
| issue_gnt | output | NT | One-hot grant |
| issue_idx | output | TW | Binary index of the granted thread (register bank select) |
| issue_vld | output | 1 | A thread is granted this cycle |

## Verification
The state that can go wrong is held in the start pointer, the load-wait flags and the two window counters. Each of these reaches the ports within a cycle or two. A wrong pointer shows on the very next grant as a rotation that skips or repeats a thread. A wrong wait flag shows as a grant to a thread that reported a stall, or as a missing grant in the cycle after its load completed. A wrong counter shows within one weight window as a 0/1 pattern with the wrong length or the wrong order. The directed scenarios reset the block before each pattern, so every expected index can be counted out by hand from the requirements.

// File: rtl/mt_issue_sel.sv
module mt_issue_sel #(
  parameter int NT = 4,
  parameter int WW = 3,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sched_mode,
  input  logic [WW-1:0] wt_a,
  input  logic [WW-1:0] wt_b,
  input  logic [NT-1:0] thr_ready,
  input  logic [NT-1:0] ld_stall,
  input  logic [NT-1:0] ld_done,
  output logic [NT-1:0] issue_gnt,
  output logic [TW-1:0] issue_idx,
  output logic          issue_vld
);

  logic [TW-1:0] ptr_q;
  logic [NT-1:0] wait_q;
  logic [WW-1:0] cnt_a_q, cnt_b_q;

  wire [NT-1:0] elig     = thr_ready & ~wait_q;
  wire          wt_mode  = sched_mode[1];
  wire          sos_mode = (sched_mode == 2'b01);

  logic          rr_hit;
  logic [TW-1:0] rr_idx, cand;
  always_comb begin
    rr_hit = 1'b0;
    rr_idx = '0;
    cand   = '0;
    for (int k = NT - 1; k >= 0; k--) begin
      cand = TW'((int'(ptr_q) + k) % NT);
      if (elig[cand]) begin
        rr_hit = 1'b1;
        rr_idx = cand;
      end
    end
  end

  wire both   = elig[0] & elig[1];
  wire a_turn = cnt_a_q < wt_a;
  wire b_turn = cnt_b_q < wt_b;
  wire pick_b = both ? (!a_turn && b_turn) : (elig[1] & ~elig[0]);
  wire wt_hit = elig[0] | elig[1];

  assign issue_vld = wt_mode ? wt_hit : rr_hit;
  assign issue_idx = wt_mode ? (pick_b ? TW'(1) : TW'(0)) : rr_idx;
  assign issue_gnt = issue_vld ? (NT'(1) << issue_idx) : '0;

  wire          inc_a = wt_mode & both & ~pick_b;
  wire          inc_b = wt_mode & both & pick_b;
  wire [WW:0]   a_nxt = {1'b0, cnt_a_q} + (WW+1)'(inc_a);
  wire [WW:0]   b_nxt = {1'b0, cnt_b_q} + (WW+1)'(inc_b);
  wire          win_end = (a_nxt >= {1'b0, wt_a}) && (b_nxt >= {1'b0, wt_b});

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      wait_q  <= '0;
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else begin
      wait_q <= (wait_q & ~ld_done) | ld_stall;
      if (issue_vld && !wt_mode)
        ptr_q <= sos_mode ? issue_idx : issue_idx + TW'(1);
      if (inc_a || inc_b) begin
        cnt_a_q <= win_end ? '0 : a_nxt[WW-1:0];
        cnt_b_q <= win_end ? '0 : b_nxt[WW-1:0];
      end
    end
  end

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
    issue_vld |-> (thr_ready[issue_idx] && $onehot0(issue_gnt))); // R1
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (thr_ready == '0) |-> (!issue_vld && issue_gnt == '0)); // R2
  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sched_mode == 2'b00 && $past(sched_mode) == 2'b00 && $past(issue_vld)
     && (&thr_ready) && wait_q == '0) |-> (issue_idx == $past(issue_idx) + TW'(1))); // R3
  AST_SOS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sched_mode == 2'b01 && $past(sched_mode) == 2'b01 && $past(issue_vld)
     && thr_ready[$past(issue_idx)] && !wait_q[$past(issue_idx)])
    |-> (issue_idx == $past(issue_idx))); // R4
  AST_STALL_SKIP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((issue_gnt & $past(ld_stall)) == '0)); // R5
  AST_WT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wt_mode && issue_vld) |-> (issue_idx < TW'(2))); // R7
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (!wt_mode && (thr_ready & ~wait_q) != '0) |-> issue_vld); // R9

endmodule

// File: tb/sim_mt_issue_sel.sv
`timescale 1ns/1ps
module sim_mt_issue_sel;
  localparam int NT = 4;
  localparam int WW = 3;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    sched_mode = 2'b00;
  logic [WW-1:0] wt_a = '0, wt_b = '0;
  logic [NT-1:0] thr_ready = '0, ld_stall = '0, ld_done = '0;
  logic [NT-1:0] issue_gnt;
  logic [TW-1:0] issue_idx;
  logic          issue_vld;

  int n_tot = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mt_issue_sel #(.NT(NT), .WW(WW)) u0 (
    .clk(clk), .rst(rst), .sched_mode(sched_mode), .wt_a(wt_a), .wt_b(wt_b),
    .thr_ready(thr_ready), .ld_stall(ld_stall), .ld_done(ld_done),
    .issue_gnt(issue_gnt), .issue_idx(issue_idx), .issue_vld(issue_vld));

  // Checks the outputs 1 ns after the negedge, then waits for the next negedge.
  task automatic expect_gnt(input bit vld, input int idx, input string req);
    logic [NT-1:0] g;
    #1;
    g = vld ? (NT'(1) << idx) : '0;
    n_tot++;
    if (issue_vld !== vld || issue_gnt !== g || (vld && issue_idx !== TW'(idx))) begin
      n_bad++;
      $display("FAIL %s: vld=%0b gnt=%b idx=%0d, expected vld=%0b gnt=%b idx=%0d",
               req, issue_vld, issue_gnt, issue_idx, vld, g, idx);
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; thr_ready = '0; ld_stall = '0; ld_done = '0; sched_mode = m;
    expect_gnt(1'b0, 0, "R2 idle during reset");
    rst = 1'b0;
  endtask

  task automatic t_rotate();
    do_reset(2'b00);
    thr_ready = 4'b1111;
    expect_gnt(1'b1, 0, "R8 first grant after reset");
    expect_gnt(1'b1, 1, "R3 rotate");
    expect_gnt(1'b1, 2, "R3 rotate");
    expect_gnt(1'b1, 3, "R3 rotate");
    expect_gnt(1'b1, 0, "R9 wrap without bubble");
    do_reset(2'b00);
    thr_ready = 4'b1010;
    expect_gnt(1'b1, 1, "R3 skip not ready");
    expect_gnt(1'b1, 3, "R3 skip not ready");
    expect_gnt(1'b1, 1, "R3 skip not ready");
    thr_ready = 4'b0000;
    expect_gnt(1'b0, 0, "R2 none ready");
  endtask

  task automatic t_sticky();
    do_reset(2'b01);
    thr_ready = 4'b1111;
    expect_gnt(1'b1, 0, "R4 hold");
    expect_gnt(1'b1, 0, "R4 hold");
    thr_ready = 4'b1110;
    expect_gnt(1'b1, 1, "R4 switch same cycle");
    expect_gnt(1'b1, 1, "R4 hold new thread");
    do_reset(2'b01);
    thr_ready = 4'b0011;
    ld_stall = 4'b0001;
    expect_gnt(1'b1, 0, "R4 owner before stall");
    ld_stall = 4'b0010;
    expect_gnt(1'b1, 1, "R5 stalled thread skipped");
    ld_stall = 4'b0000; ld_done = 4'b0001;
    expect_gnt(1'b0, 0, "R5 not eligible in done cycle");
    ld_done = 4'b0000;
    expect_gnt(1'b1, 0, "R5 eligible after done");
    ld_stall = 4'b0001; ld_done = 4'b0011;
    expect_gnt(1'b1, 0, "R4 owner in tie cycle");
    ld_stall = 4'b0000; ld_done = 4'b0000;
    expect_gnt(1'b1, 1, "R5 stall wins over done");
  endtask

  task automatic t_weighted();
    do_reset(2'b10);
    thr_ready = 4'b1111; wt_a = 3'd3; wt_b = 3'd1;
    for (int r = 0; r < 2; r++) begin
      expect_gnt(1'b1, 0, "R6 3:1 window");
      expect_gnt(1'b1, 0, "R6 3:1 window");
      expect_gnt(1'b1, 0, "R6 3:1 window");
      expect_gnt(1'b1, 1, "R6 3:1 window");
    end
    do_reset(2'b11);
    thr_ready = 4'b1111; wt_a = 3'd1; wt_b = 3'd2;
    for (int r = 0; r < 2; r++) begin
      expect_gnt(1'b1, 0, "R6 1:2 window");
      expect_gnt(1'b1, 1, "R6 1:2 window");
      expect_gnt(1'b1, 1, "R6 1:2 window");
    end
    wt_a = 3'd0; wt_b = 3'd0;
    expect_gnt(1'b1, 0, "R6 zero weights");
    expect_gnt(1'b1, 0, "R6 zero weights");
  endtask

  task automatic t_weighted_single();
    do_reset(2'b10);
    wt_a = 3'd3; wt_b = 3'd1;
    thr_ready = 4'b1110;
    expect_gnt(1'b1, 1, "R7 only thread 1 eligible");
    expect_gnt(1'b1, 1, "R7 only thread 1 eligible");
    thr_ready = 4'b1100;
    expect_gnt(1'b0, 0, "R7 threads 2,3 never granted");
    thr_ready = 4'b0011;
    expect_gnt(1'b1, 0, "R7 window unchanged");
    expect_gnt(1'b1, 0, "R7 window unchanged");
    expect_gnt(1'b1, 0, "R7 window unchanged");
    expect_gnt(1'b1, 1, "R7 window unchanged");
  endtask

  initial begin
    #(5.0 * 100000);
    n_tot++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end

  initial begin
    t_rotate();
    t_sticky();
    t_weighted();
    t_weighted_single();
    $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
    $finish;
  end
endmodule